// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (Master or Slave)

This block is an 8-bit synchronous serial port for a small microcontroller. A simple register port gives the CPU two registers: a data register, written to start a byte transfer and read to fetch the byte that came back, and a control register that selects master or slave operation, clock polarity, clock phase, master bit rate and whether the end-of-byte flag raises an interrupt. Every transfer moves one byte each way, most significant bit first, one bit per serial clock period.

In master mode the block drives the serial clock and produces a burst of eight clock periods for each write. The half period of that clock is 1, 2, 4 or 8 system clocks. In slave mode the serial clock and the active-low select arrive from outside. They pass through a two-flop synchronizer, so the system clock must run at least four times the serial clock. When a byte ends, the shifted-in byte is copied into the data register and a sticky flag is set. Software clears the flag with a dedicated strobe.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, the data register reads 0x00, the control register reads 0x00, the flag, interrupt and busy outputs are 0, and the serial clock output is 0.
- R2: In master mode (control bit 2 = 1), a data write (reg_sel = 0) while idle makes exactly 16 serial clock edges, which is eight periods. The rate field (control bits 4:3) sets the spacing between edges, and the write-to-first-edge delay, to 2^rate system clocks. After the last edge, busy drops.
- R3: The master drives the written byte on mosi_o, MSB first, and shifts in miso_i. With clock phase 0 (control bit 0) it samples on the first (leading) edge of each period and changes data on the second. With phase 1 it changes data on the leading edge and samples on the trailing edge. This holds for both polarities (control bit 1).
- R4: At the end of each byte the received byte appears on data_rd and irq_flag is set. irq is 1 only when irq_flag is 1 and the interrupt enable (control bit 5) is 1.
- R5: irq_flag stays at 1 until flag_clr is pulsed, and then it reads 0.
- R6: A data write while busy is 1 is ignored. The running transfer still sends the first byte, and data_rd ends with the received byte.
- R7: In master mode the level and activity of ss_n_i have no effect on the transfer.
- R8: In slave mode, edges on sck_i while ss_n_i is high are ignored. No flag is set and the data register keeps its value.
- R9: In slave mode with phase 1, the byte completes after the eighth received clock period, while ss_n_i is still low.
- R10: In slave mode with phase 0, the byte does not complete after the eighth clock period. It completes when ss_n_i returns high.
- R11: When the master is idle, sck_o rests at the polarity bit. sck_oe equals the master bit.
- R12: In slave mode the byte written before select is sent on miso_o, MSB first, with the same edge rules as R3, and the byte received on mosi_i is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = data register, 1 = control register |
| reg_wdata | input | 8 | Write data |
| flag_clr | input | 1 | Clears the end-of-byte flag |
| data_rd | output | 8 | Data register contents |
| ctrl_rd | output | 8 | Control register contents |
| irq_flag | output | 1 | Sticky end-of-byte flag |
| irq | output | 1 | Interrupt request (flag and enable) |
| busy | output | 1 | Transfer in progress (master burst, or select held in slave) |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock input (slave) |
| ss_n_i | input | 1 | Active-low select input (slave) |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |

## Verification
The master is swept over all four polarity and phase combinations at all four rates. Each run uses a different pair of transmit and receive bytes, so an error in bit order, edge choice or edge spacing changes a captured value. The slave is driven through all four modes with two byte pairs. The two phases are told apart by whether the flag rises before or only after the select is released. Further runs cover writes during a burst, select activity during master transfers, clock edges with select high, an interrupt with the enable off, and how long the flag stays set.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int DATA_W   = 8;
    localparam int RATE_W   = 2;
    localparam int EDGES    = 2 * DATA_W;
    localparam int ECNT_W   = $clog2(EDGES);
    localparam int DIV_W    = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [1:0]        spare;
        logic              ien;
        logic [RATE_W-1:0] rate;
        logic              master;
        logic              cpol;
        logic              cpha;
    } sbp_ctrl_t;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } sbp_sel_e;

    // Edge index counts from 0; even indices are leading edges.
    function automatic logic edge_samples(input logic [ECNT_W-1:0] idx,
                                          input logic cpha);
        return idx[0] == cpha;
    endfunction

endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbp_divider.sv
module sbp_divider
    import sbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb lim = DIV_W'((32'd1 << rate) - 32'd1);

    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DIV_W'(1);
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (cnt == '0)); // R2
endmodule

// File: rtl/sbp_engine.sv
module sbp_engine
    import sbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              start,
    input  logic [DATA_W-1:0] start_byte,
    input  logic              edge_ev,
    input  logic              rx_bit,
    input  logic              ss_act,
    input  logic              ss_rise,
    output logic              tx_bit,
    output logic              sck_out,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    logic              busy_m;
    logic [DATA_W-1:0] shreg;
    logic              tx_q;
    logic              sck_q;
    logic [ECNT_W-1:0] ecnt;
    logic              rx_ready;
    logic              sample;
    logic              last;
    logic [DATA_W-1:0] nxt_shift;

    assign sample    = edge_samples(ecnt, cpha);
    assign last      = (ecnt == ECNT_W'(EDGES - 1));
    assign nxt_shift = {shreg[DATA_W-2:0], rx_bit};
    assign rx_byte   = (edge_ev && sample) ? nxt_shift : shreg;

    assign done = (edge_ev && last && (master || cpha))
               || (!master && !cpha && ss_rise && rx_ready);

    assign busy    = master ? busy_m : ss_act;
    assign tx_bit  = tx_q;
    assign sck_out = sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_m   <= 1'b0;
            shreg    <= '0;
            tx_q     <= 1'b0;
            sck_q    <= 1'b0;
            ecnt     <= '0;
            rx_ready <= 1'b0;
        end else begin
            if (master && busy_m) begin
                if (edge_ev) sck_q <= ~sck_q;
            end else begin
                sck_q <= cpol;
            end

            if (start) begin
                shreg    <= start_byte;
                tx_q     <= start_byte[DATA_W-1];
                ecnt     <= '0;
                busy_m   <= master;
                rx_ready <= 1'b0;
            end else if (edge_ev) begin
                if (sample) shreg <= nxt_shift;
                else        tx_q  <= shreg[DATA_W-1];
                ecnt <= ecnt + ECNT_W'(1);
                if (last) begin
                    busy_m <= 1'b0;
                    if (!cpha) rx_ready <= 1'b1;
                end
            end

            if (!master && !ss_act) begin
                ecnt     <= '0;
                rx_ready <= 1'b0;
            end
        end
    end

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(master && busy_m) |=> (sck_q == $past(cpol))); // R11
    AST_SLAVE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (!master && !ss_act) |=> (ecnt == '0)); // R8
    AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
        (master && busy_m && edge_ev && last) |=> !busy_m); // R2
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import sbp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       flag_clr,
    output logic [7:0] data_rd,
    output logic [7:0] ctrl_rd,
    output logic       irq_flag,
    output logic       irq,
    output logic       busy,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sck_i,
    input  logic       ss_n_i,
    output logic       mosi_o,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic       miso_i
);
    sbp_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] data_q;
    logic              flag_q;

    logic [2:0] pins_s;
    logic       sck_prev, ss_prev;
    logic       ss_act, ss_rise, sck_chg;
    logic       tick, edge_ev, rx_bit, tx_bit, done;
    logic       wr_data, start;
    logic [DATA_W-1:0] rx_byte;

    sbp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mosi_i, ss_n_i, sck_i}),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            ss_prev  <= 1'b1;
        end else begin
            sck_prev <= pins_s[0];
            ss_prev  <= pins_s[1];
        end
    end

    assign ss_act  = !pins_s[1];
    assign ss_rise = pins_s[1] && !ss_prev;
    assign sck_chg = pins_s[0] ^ sck_prev;

    sbp_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.master && busy),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    assign edge_ev = ctrl_q.master ? tick : (ss_act && sck_chg);
    assign rx_bit  = ctrl_q.master ? miso_i : pins_s[2];
    assign wr_data = reg_wr && (sbp_sel_e'(reg_sel) == SEL_DATA);
    assign start   = wr_data && !busy;

    sbp_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .master     (ctrl_q.master),
        .cpol       (ctrl_q.cpol),
        .cpha       (ctrl_q.cpha),
        .start      (start),
        .start_byte (reg_wdata),
        .edge_ev    (edge_ev),
        .rx_bit     (rx_bit),
        .ss_act     (ss_act),
        .ss_rise    (ss_rise),
        .tx_bit     (tx_bit),
        .sck_out    (sck_o),
        .busy       (busy),
        .done       (done),
        .rx_byte    (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (reg_wr && (sbp_sel_e'(reg_sel) == SEL_CTRL))
                ctrl_q <= sbp_ctrl_t'(reg_wdata);
            if (done)       data_q <= rx_byte;
            else if (start) data_q <= reg_wdata;
            if (done)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign data_rd  = data_q;
    assign ctrl_rd  = ctrl_q;
    assign irq_flag = flag_q;
    assign irq      = flag_q && ctrl_q.ien;
    assign sck_oe   = ctrl_q.master;
    assign mosi_o   = ctrl_q.master ? tx_bit : 1'b0;
    assign miso_o   = ctrl_q.master ? 1'b0 : tx_bit;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q); // R5
    AST_DONE_LOADS: assert property (@(posedge clk) disable iff (rst)
        done |=> (flag_q && data_q == $past(rx_byte))); // R4
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy && !done) |=> (data_q == $past(data_q))); // R6
endmodule

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_sel = 1'b0, flag_clr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] data_rd, ctrl_rd;
    logic       irq_flag, irq, busy, sck_o, sck_oe;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
    logic       mosi_o, miso_o;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_byte_port u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .flag_clr(flag_clr), .data_rd(data_rd),
        .ctrl_rd(ctrl_rd), .irq_flag(irq_flag), .irq(irq), .busy(busy),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .ss_n_i(ss_n_i),
        .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Bench acts as the external slave while the design is master.
    task automatic master_xfer(input logic cpol, input logic cpha, input int rate,
                               input logic [7:0] tx, input logic [7:0] rx,
                               input logic ien, input bit inject, input int ss_mode);
        int h = 1 << rate;
        int ec = 0;
        int tbad = 0;
        int j;
        logic [7:0] cap = 8'h00;
        logic prev;
        reg_write(1'b1, {2'b00, ien, rate[1:0], 1'b1, cpol, cpha});
        pulse_clear();
        ss_n_i = (ss_mode == 1) ? 1'b0 : 1'b1;
        @(negedge clk);
        miso_i = cpha ? 1'b0 : rx[7];
        j = cpha ? 0 : 1;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = tx;
        prev = sck_o;
        for (int t = 1; t <= 16 * h + 4; t++) begin
            @(negedge clk);
            if (t == 1) reg_wr = 1'b0;
            if (inject && t == 3) begin reg_wr = 1'b1; reg_wdata = ~tx; end
            if (inject && t == 4) reg_wr = 1'b0;
            if (ss_mode == 2) ss_n_i = t[0];
            if (t == 16 * h) check(busy == 1'b1, "R2", "busy before last edge", busy, 1);
            if (sck_o != prev) begin
                ec++;
                if (t != 1 + ec * h) tbad++;
                if (ec[0] ^ cpha) cap = {cap[6:0], mosi_o};
                else if (j < 8) begin miso_i = rx[7 - j]; j++; end
                prev = sck_o;
            end
        end
        check(ec == 16, "R2", "edge count", ec, 16);
        check(tbad == 0, "R2", "edge spacing errors", tbad, 0);
        check(busy == 1'b0, "R2", "busy after burst", busy, 0);
        check(cap == (inject ? tx : tx), inject ? "R6" : (ss_mode != 0 ? "R7" : "R3"),
              "mosi byte", cap, tx);
        check(data_rd == rx, inject ? "R6" : "R3", "received byte", data_rd, rx);
        check(irq_flag == 1'b1, "R4", "flag at end", irq_flag, 1);
        check(irq == ien, "R4", "irq gating", irq, ien);
        check(sck_o == cpol && sck_oe == 1'b1, "R11", "idle sck/oe",
              {sck_oe, sck_o}, {1'b1, cpol});
    endtask

    // Bench acts as the external master while the design is slave.
    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] tx, input logic [7:0] rx);
        localparam int H = 6;
        int j;
        logic [7:0] cap = 8'h00;
        reg_write(1'b1, {2'b00, 1'b1, 2'b00, 1'b0, cpol, cpha});
        sck_i = cpol; ss_n_i = 1'b1; mosi_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_clear();
        reg_write(1'b0, tx);
        check(sck_oe == 1'b0, "R11", "slave sck_oe", sck_oe, 0);
        @(negedge clk);
        ss_n_i = 1'b0;
        mosi_i = cpha ? 1'b0 : rx[7];
        j = cpha ? 0 : 1;
        repeat (H) @(negedge clk);
        for (int k = 1; k <= 16; k++) begin
            bit samp = k[0] ^ cpha;
            if (samp) cap = {cap[6:0], miso_o};
            sck_i = ~sck_i;
            if (!samp && j < 8) begin mosi_i = rx[7 - j]; j++; end
            repeat (H) @(negedge clk);
        end
        if (cpha) begin
            check(irq_flag == 1'b1, "R9", "flag before select release", irq_flag, 1);
            check(data_rd == rx, "R9", "received byte", data_rd, rx);
        end else begin
            check(irq_flag == 1'b0, "R10", "flag before select release", irq_flag, 0);
            check(data_rd == tx, "R10", "data held until release", data_rd, tx);
        end
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        check(irq_flag == 1'b1, cpha ? "R9" : "R10", "flag after release", irq_flag, 1);
        check(data_rd == rx, cpha ? "R9" : "R10", "final byte", data_rd, rx);
        check(cap == tx, "R12", "miso byte", cap, tx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(data_rd == 8'h00, "R1", "data reset", data_rd, 0);
        check(ctrl_rd == 8'h00, "R1", "ctrl reset", ctrl_rd, 0);
        check({irq_flag, irq, busy, sck_o} == 4'b0000, "R1", "flags/busy/sck reset",
              {irq_flag, irq, busy, sck_o}, 0);

        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] tx = 8'(8'h5A + m * 37 + r * 11);
                logic [7:0] rx = 8'(8'hC3 ^ (m * 16 + r * 3 + 1));
                master_xfer(m[1], m[0], r, tx, rx, 1'b1, 1'b0, 0);
            end
        end

        // R6: second write during a burst
        master_xfer(1'b0, 1'b1, 2, 8'h96, 8'h3E, 1'b1, 1'b1, 0);
        // R7: select held low, then toggling, in master mode
        master_xfer(1'b1, 1'b0, 1, 8'hB4, 8'h5D, 1'b1, 1'b0, 1);
        master_xfer(1'b0, 1'b0, 0, 8'h2F, 8'hE8, 1'b1, 1'b0, 2);
        // R4: interrupt enable off
        master_xfer(1'b1, 1'b1, 1, 8'h71, 8'h8C, 1'b0, 1'b0, 0);

        // R5: flag stays until cleared
        repeat (50) @(negedge clk);
        check(irq_flag == 1'b1, "R5", "flag held", irq_flag, 1);
        pulse_clear();
        check(irq_flag == 1'b0, "R5", "flag cleared", irq_flag, 0);

        for (int m = 0; m < 4; m++) begin
            slave_xfer(m[1], m[0], 8'(8'hA6 + m * 29), 8'(8'h19 ^ (m * 68)));
            slave_xfer(m[1], m[0], 8'(8'h0F ^ (m * 85)), 8'(8'hF0 - m * 7));
        end

        // R8: clock edges with select high
        reg_write(1'b1, 8'h01);
        pulse_clear();
        reg_write(1'b0, 8'h3C);
        mosi_i = 1'b1;
        ss_n_i = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sck_i = ~sck_i;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check(irq_flag == 1'b0, "R8", "no flag while deselected", irq_flag, 0);
        check(data_rd == 8'h3C, "R8", "data kept", data_rd, 8'h3C);
        check(busy == 1'b0, "R8", "not busy", busy, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule